// File: doc/BRIEF.md
# Universal serial shift interface

This block is a bare serial engine that a host processor steers with a small amount of software. An 8-bit shift register sends its most significant bit out and takes a new bit in from the data input line at its least significant end. A 4-bit counter counts clock edges and raises an overflow flag when it wraps. The shift clock can come from a software strobe, from a timer compare event, or from the external clock line, sampled on its rising or its falling edge. The same engine serves a three-wire link, with a separate data output, and a two-wire link, where the data and clock lines are open-drain. In the two-wire case the block also detects start and stop conditions and can hold the clock line low.

The output bit passes through a latch that is open only during the clock phase after the non-sampling edge. The data output therefore moves on the edge opposite to the sampling edge. The host reads and writes three registers over a simple single-cycle register bus. Addressing, acknowledge policy and arbitration are left to software. The clock and data pins go through a synchronizer, so each pin event acts on the logic a few system clocks after it happens.

Top module: `sync_shift_if`

## Requirements
- R1: After reset the data, status and control registers read 0, and do_out, sda_drive_low, scl_drive_low, irq_done and irq_start are all 0.
- R2: Address 0 is the data register. Address 1 is the status register: bit7 start flag, bit6 overflow flag, bit5 stop flag, bit4 reads 0, bits3:0 the count. Address 2 is the control register: bit7 start interrupt enable, bit6 overflow interrupt enable, bits5:4 wire mode, bits3:2 clock select, bit1 strobe, bit0 clock toggle; bits 1 and 0 always read 0. A host write to data or count in the same cycle as a shift or count event takes priority.
- R3: The clock select field chooses the clock: 00 means one shift and one count per strobe write, 01 one per timer event, 10 the external clock with sampling on its rising edge, and 11 the external clock with sampling on its falling edge. In both external modes the counter advances on every clock edge.
- R4: Each shift moves the register one place toward the MSB and loads the sampled data input line into bit 0, so a byte is sent and received MSB first.
- R5: In the external clock modes the output bit stays unchanged across the sampling edge and takes the new MSB only after the opposite edge.
- R6: A count event at count 15 wraps the count to 0 and sets the overflow flag. Writing 1 to a status flag clears it, but a set in the same cycle overrides the clear. irq_done is high while the overflow flag and its enable are both set.
- R7: With wire mode 01 (three-wire), do_out carries the output bit. With wire mode 10 or 11 (two-wire), do_out is 0 and sda_drive_low is the inverse of the output bit. With wire mode 00, both are 0.
- R8: In two-wire mode, a fall of the data line while the clock line is high sets the start flag and drives scl_drive_low until the flag is cleared. irq_start is high while the flag and its enable are both set. A fall of the data line while the clock line is low sets nothing.
- R9: In two-wire mode, a rise of the data line while the clock line is high sets the stop flag. This does not hold the clock line.
- R10: With wire mode 11, a set overflow flag drives scl_drive_low until software clears it.
- R11: In two-wire mode, each control write with bit0 set toggles the clock line pull-down. In an external clock mode, the counter counts the resulting edges on the clock line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from bus_addr) |
| di_in | input | 1 | Data input line (also the two-wire data line level) |
| sck_in | input | 1 | Clock line level |
| tmr_evt | input | 1 | Timer compare event, one cycle wide |
| do_out | output | 1 | Three-wire data output |
| sda_drive_low | output | 1 | Pull-down enable for the open-drain data line |
| scl_drive_low | output | 1 | Pull-down enable for the open-drain clock line |
| irq_done | output | 1 | Counter overflow interrupt |
| irq_start | output | 1 | Start condition interrupt |

## Verification
A shift and count event and a host register write can fall in the same cycle. Both act on the count, and on the overflow flag when that flag is set by a wrap and cleared by the write. The bench causes this by pulsing the timer event in the same cycle as a status write that clears the overflow flag and presets the count. It expects the flag to stay set and the count to take the written value. In a similar test, a data write that coincides with a timer shift must leave the written byte in the register.

// File: rtl/sshi_pkg.sv
package sshi_pkg;
  typedef enum logic [1:0] {
    WM_OFF      = 2'b00,
    WM_THREE    = 2'b01,
    WM_TWO      = 2'b10,
    WM_TWO_HOLD = 2'b11
  } wire_mode_e;

  typedef enum logic [1:0] {
    CS_STROBE   = 2'b00,
    CS_TIMER    = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_sel_e;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;

  // Sampling phase of the output latch: open during the phase after the
  // non-sampling edge, always open for the internal clock sources.
  function automatic logic latch_open(input clk_sel_e cs, input logic scl_lvl);
    case (cs)
      CS_EXT_RISE: latch_open = !scl_lvl;
      CS_EXT_FALL: latch_open = scl_lvl;
      default:     latch_open = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sshi_sync.sv
module sshi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sshi_clksel.sv
module sshi_clksel
  import sshi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_lvl,
  input  clk_sel_e csel,
  input  logic     strobe,
  input  logic     tmr_evt,
  output logic     shift_evt,
  output logic     cnt_evt,
  output logic     transparent
);
  logic scl_prev;
  logic scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_prev <= 1'b0;
    else        scl_prev <= scl_lvl;
  end

  assign scl_rise = scl_lvl && !scl_prev;
  assign scl_fall = !scl_lvl && scl_prev;

  always_comb begin
    case (csel)
      CS_STROBE: begin
        shift_evt = strobe;
        cnt_evt   = strobe;
      end
      CS_TIMER: begin
        shift_evt = tmr_evt;
        cnt_evt   = tmr_evt;
      end
      CS_EXT_RISE: begin
        shift_evt = scl_rise;
        cnt_evt   = scl_rise || scl_fall;
      end
      default: begin
        shift_evt = scl_fall;
        cnt_evt   = scl_rise || scl_fall;
      end
    endcase
  end

  assign transparent = latch_open(csel, scl_lvl);
endmodule

// File: rtl/sshi_cond.sv
module sshi_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sda_lvl,
  input  logic scl_lvl,
  output logic start_det,
  output logic stop_det
);
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b0;
    else        sda_prev <= sda_lvl;
  end

  assign start_det = enable && scl_lvl && sda_prev && !sda_lvl;
  assign stop_det  = enable && scl_lvl && !sda_prev && sda_lvl;
endmodule

// File: rtl/sync_shift_if.sv
module sync_shift_if
  import sshi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              di_in,
  input  logic              sck_in,
  input  logic              tmr_evt,
  output logic              do_out,
  output logic              sda_drive_low,
  output logic              scl_drive_low,
  output logic              irq_done,
  output logic              irq_start
);
  localparam int MSB     = DATA_W - 1;
  localparam int PAD_W   = DATA_W - CNT_W - 3;
  localparam int B_START = DATA_W - 1;
  localparam int B_OVF   = DATA_W - 2;
  localparam int B_STOP  = DATA_W - 3;

  // Synchronized pin levels
  logic sda_lvl, scl_lvl;
  sshi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({di_in, sck_in}), .q({sda_lvl, scl_lvl})
  );

  // Register state
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              start_f, ovf_f, stop_f;
  logic              start_ie, ovf_ie;
  wire_mode_e        mode;
  clk_sel_e          csel;
  logic              scl_tog;
  logic              held;

  // Named internal events
  logic wr_data, wr_stat, wr_ctrl;
  logic strobe, toggle;
  logic shift_evt, cnt_evt, transparent;
  logic start_det, stop_det;
  logic ovf_set;
  logic two_wire, three_wire, hold_mode, ext_mode;
  logic do_val;

  assign wr_data    = bus_we && (bus_addr == ADR_DATA);
  assign wr_stat    = bus_we && (bus_addr == ADR_STAT);
  assign wr_ctrl    = bus_we && (bus_addr == ADR_CTRL);
  assign two_wire   = (mode == WM_TWO) || (mode == WM_TWO_HOLD);
  assign three_wire = (mode == WM_THREE);
  assign hold_mode  = (mode == WM_TWO_HOLD);
  assign ext_mode   = (csel == CS_EXT_RISE) || (csel == CS_EXT_FALL);
  assign strobe     = wr_ctrl && bus_wdata[1];
  assign toggle     = wr_ctrl && bus_wdata[0] && two_wire;

  sshi_clksel u_clksel (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .csel(csel),
    .strobe(strobe), .tmr_evt(tmr_evt),
    .shift_evt(shift_evt), .cnt_evt(cnt_evt), .transparent(transparent)
  );

  sshi_cond u_cond (
    .clk(clk), .rst_n(rst_n), .enable(two_wire),
    .sda_lvl(sda_lvl), .scl_lvl(scl_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign ovf_set = cnt_evt && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      start_f  <= 1'b0;
      ovf_f    <= 1'b0;
      stop_f   <= 1'b0;
      start_ie <= 1'b0;
      ovf_ie   <= 1'b0;
      mode     <= WM_OFF;
      csel     <= CS_STROBE;
      scl_tog  <= 1'b0;
      held     <= 1'b0;
    end else begin
      if (wr_data)        sr <= bus_wdata;
      else if (shift_evt) sr <= {sr[MSB-1:0], sda_lvl};

      if (wr_stat)      cnt <= bus_wdata[CNT_W-1:0];
      else if (cnt_evt) cnt <= cnt + 1'b1;

      if (ovf_set)                         ovf_f <= 1'b1;
      else if (wr_stat && bus_wdata[B_OVF]) ovf_f <= 1'b0;
      if (start_det)                           start_f <= 1'b1;
      else if (wr_stat && bus_wdata[B_START]) start_f <= 1'b0;
      if (stop_det)                           stop_f <= 1'b1;
      else if (wr_stat && bus_wdata[B_STOP]) stop_f <= 1'b0;

      if (wr_ctrl) begin
        start_ie <= bus_wdata[7];
        ovf_ie   <= bus_wdata[6];
        mode     <= wire_mode_e'(bus_wdata[5:4]);
        csel     <= clk_sel_e'(bus_wdata[3:2]);
      end

      if (!two_wire)   scl_tog <= 1'b0;
      else if (toggle) scl_tog <= !scl_tog;

      if (transparent) held <= sr[MSB];
    end
  end

  assign do_val        = transparent ? sr[MSB] : held;
  assign do_out        = three_wire && do_val;
  assign sda_drive_low = two_wire && !do_val;
  assign scl_drive_low = two_wire && (scl_tog || start_f || (hold_mode && ovf_f));
  assign irq_done      = ovf_f && ovf_ie;
  assign irq_start     = start_f && start_ie;

  always_comb begin
    case (bus_addr)
      ADR_DATA: bus_rdata = sr;
      ADR_STAT: bus_rdata = {start_f, ovf_f, stop_f, {PAD_W{1'b0}}, cnt};
      ADR_CTRL: bus_rdata = {start_ie, ovf_ie, mode, csel, {(DATA_W-6){1'b0}}};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sshi_chk.sv
module sshi_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_evt,
  input logic              cnt_evt,
  input logic              wr_data,
  input logic              wr_stat,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf_f,
  input logic              start_f,
  input logic              two_wire,
  input logic              ext_mode,
  input logic              do_val,
  input logic [DATA_W-1:0] sr
);
  // R6: the overflow flag rises only from a count event at the top count
  a_r6_ovf_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_f) |-> ($past(cnt_evt) && ($past(cnt) == {CNT_W{1'b1}})));

  // R8: the start flag rises only while two-wire mode is active
  a_r8_start_two_wire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_f) |-> $past(two_wire));

  // R4: the shift register moves only on a shift event or a host write
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(shift_evt) && !$past(wr_data)) |-> $stable(sr));

  // R5: the output bit does not move on the sampling edge
  a_r5_opposite_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode) && shift_evt) |-> $stable(do_val));

  // R3: each count event without a host preset advances the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !wr_stat) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

bind sync_shift_if sshi_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .cnt_evt(cnt_evt),
  .wr_data(wr_data), .wr_stat(wr_stat), .cnt(cnt), .ovf_f(ovf_f),
  .start_f(start_f), .two_wire(two_wire), .ext_mode(ext_mode),
  .do_val(do_val), .sr(sr)
);

// File: tb/test_sync_shift_if.sv
`timescale 1ns/1ps
module test_sync_shift_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_evt = 1'b0;
  logic       scl_bench = 1'b0, sda_bench = 1'b1;
  logic       do_out, sda_drive_low, scl_drive_low, irq_done, irq_start;
  logic       sda_line, scl_line;
  int         checks = 0, errors = 0;

  assign sda_line = sda_bench && !sda_drive_low;
  assign scl_line = scl_bench && !scl_drive_low;

  always #10 clk = ~clk;

  sync_shift_if i_sync_shift_if (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .di_in(sda_line),
    .sck_in(scl_line), .tmr_evt(tmr_evt), .do_out(do_out),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .irq_done(irq_done), .irq_start(irq_start)
  );

  function automatic logic [7:0] stat(input logic s, o, p, input logic [3:0] c);
    return {s, o, p, 1'b0, c};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tmr_pulse();
    @(negedge clk); tmr_evt = 1'b1;
    @(negedge clk); tmr_evt = 1'b0;
  endtask

  task automatic ext_xfer(input logic fallm, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] rd;
    scl_bench = fallm; idle(4);
    bus_write(2'd2, fallm ? 8'h5C : 8'h58);
    bus_write(2'd1, 8'h60);
    bus_write(2'd0, tx);
    idle(2);
    for (int i = 7; i >= 0; i--) begin
      sda_bench = rx[i]; idle(4);
      check("R7 ext do before sample", do_out, tx[i]);
      scl_bench = !fallm; idle(4);
      check("R5 do held over sample edge", do_out, tx[i]);
      if (i == 0) begin
        bus_read(2'd1, rd);
        check("R6 count 15 no ovf", rd, stat(0, 0, 0, 4'hF));
      end
      scl_bench = fallm; idle(4);
    end
    bus_read(2'd1, rd);
    check("R6 ovf after 16 edges", rd, stat(0, 1, 0, 4'h0));
    check("R6 irq_done", irq_done, 1);
    bus_read(2'd0, rd);
    check("R4 ext rx byte", rd, rx);
  endtask

  initial begin
    logic [7:0] rd, tx, rx;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    bus_read(2'd0, rd); check("R1 data", rd, 0);
    bus_read(2'd1, rd); check("R1 status", rd, 0);
    bus_read(2'd2, rd); check("R1 control", rd, 0);
    check("R1 outs", {do_out, sda_drive_low, scl_drive_low, irq_done, irq_start}, 0);

    // R2 register map
    bus_write(2'd0, 8'h3C); bus_read(2'd0, rd); check("R2 data rw", rd, 8'h3C);
    bus_write(2'd2, 8'hDB); bus_read(2'd2, rd); check("R2 ctrl pulse bits read 0", rd, 8'hD8);
    bus_write(2'd1, 8'h05); bus_read(2'd1, rd); check("R2 count preset", rd, 8'h05);

    // R3 strobe clocking, R4 shift, R7 three-wire output
    bus_write(2'd2, 8'h10);
    tx = 8'($urandom); rx = 8'($urandom);
    bus_write(2'd1, 8'h60); bus_write(2'd0, tx);
    for (int i = 7; i >= 0; i--) begin
      sda_bench = rx[i]; idle(3);
      check("R7 strobe do", do_out, tx[i]);
      bus_write(2'd2, 8'h12);
    end
    bus_read(2'd0, rd); check("R4 strobe rx", rd, rx);
    bus_read(2'd1, rd); check("R3 strobe count 8", rd, stat(0, 0, 0, 4'd8));

    // R3 timer clocking, random bytes
    bus_write(2'd2, 8'h14);
    for (int k = 0; k < 3; k++) begin
      rx = 8'($urandom);
      bus_write(2'd1, 8'h60);
      for (int i = 7; i >= 0; i--) begin
        sda_bench = rx[i]; idle(3); tmr_pulse();
      end
      bus_read(2'd0, rd); check("R3 timer rx", rd, rx);
      bus_read(2'd1, rd); check("R3 timer count 8", rd, stat(0, 0, 0, 4'd8));
    end

    // R5 R6 external clock, both sampling edges
    ext_xfer(1'b0, 8'($urandom), 8'($urandom));
    ext_xfer(1'b0, 8'hA5, 8'h5A);
    ext_xfer(1'b1, 8'($urandom), 8'($urandom));

    // R6 set beats clear; R2 host preset beats count event
    bus_write(2'd2, 8'h54); bus_write(2'd1, 8'h6F);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h43; bus_we = 1'b1; tmr_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tmr_evt = 1'b0;
    bus_read(2'd1, rd); check("R6 set wins, R2 preset wins", rd, 8'h43);
    check("R6 irq_done after collision", irq_done, 1);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h81; bus_we = 1'b1; tmr_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tmr_evt = 1'b0;
    bus_read(2'd0, rd); check("R2 data write wins over shift", rd, 8'h81);

    // R8 R9 two-wire start and stop
    bus_write(2'd0, 8'hFF);
    scl_bench = 1'b1; sda_bench = 1'b1;
    bus_write(2'd2, 8'hA8); bus_write(2'd1, 8'hE0); idle(4);
    sda_bench = 1'b0; idle(5);
    bus_read(2'd1, rd); check("R8 start flag", rd & 8'hE0, 8'h80);
    check("R8 irq_start", irq_start, 1);
    check("R8 scl hold", scl_drive_low, 1);
    bus_write(2'd1, 8'h80); idle(5);
    check("R8 hold released", scl_drive_low, 0);
    sda_bench = 1'b1; idle(5);
    bus_read(2'd1, rd); check("R9 stop flag", rd & 8'hE0, 8'h20);
    check("R9 no hold on stop", scl_drive_low, 0);
    scl_bench = 1'b0; idle(4);
    sda_bench = 1'b0; idle(5);
    bus_read(2'd1, rd); check("R8 fall with scl low ignored", rd & 8'hE0, 8'h20);
    check("R8 irq_start low", irq_start, 0);
    sda_bench = 1'b1;
    bus_write(2'd0, 8'h00); idle(1);
    check("R7 two-wire sda pull", sda_drive_low, 1);
    check("R7 two-wire do_out 0", do_out, 0);
    bus_write(2'd0, 8'hFF); idle(1);
    check("R7 two-wire sda release", sda_drive_low, 0);

    // R11 toggle clock
    scl_bench = 1'b1; bus_write(2'd2, 8'h28); idle(4);
    bus_write(2'd1, 8'hE0);
    bus_write(2'd2, 8'h29); idle(5);
    check("R11 toggle pulls scl", scl_drive_low, 1);
    bus_read(2'd1, rd); check("R11 one edge counted", rd, stat(0, 0, 0, 4'd1));
    bus_write(2'd2, 8'h29); idle(5);
    check("R11 toggle releases scl", scl_drive_low, 0);
    bus_read(2'd1, rd); check("R11 two edges counted", rd, stat(0, 0, 0, 4'd2));

    // R10 hold on overflow
    bus_write(2'd2, 8'h30); bus_write(2'd1, 8'hEF);
    bus_write(2'd2, 8'h32); idle(1);
    bus_read(2'd1, rd); check("R10 ovf set", rd, stat(0, 1, 0, 4'd0));
    check("R10 scl hold on ovf", scl_drive_low, 1);
    bus_write(2'd1, 8'h40); idle(1);
    check("R10 hold released", scl_drive_low, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule